// File: doc/BRIEF.md
# Scatter-Gather Bus-Master DMA Controller

This block is a two-channel bus-master DMA engine for a disk-style data path. Software programs each channel through a small I/O register window: a command byte, a status byte and a 32-bit pointer to a table of descriptors in system memory. Setting the start bit makes the engine load the first descriptor. After that, each transfer request from the drive side moves bytes between a byte stream and the memory buffers that the table lists. A request may end partway through a buffer, on a buffer boundary, cleanly at the last entry, or with data still left over. Status bits and a result code on the request port report which of these happened.

Each descriptor is two little-endian 32-bit words. The first word is the buffer address. The second word carries the byte count and a last-entry flag. A single engine serves both channels, so only one fetch or transfer runs at a time. A level-sensitive interrupt input for each channel is reflected into status and drives an interrupt output for that channel.

Top module: `sg_busmaster_dma`

## Requirements
- R1: The two windows are decoded from `io_base` with its bits 3:0 treated as zero. Channel 0 is at base+0..7 and channel 1 at base+8..15. Both windows respond only when `io_en` is 1 and the masked base is nonzero. Otherwise reads return 0xFF and writes change nothing.
- R2: Offset 0 is the command byte and reads back as written. When bit 0 goes from 0 to 1, the table pointer is copied into the working pointer, the descriptor there is fetched and status bit 0 (active) is set. When bit 0 goes from 1 to 0, active is cleared.
- R3: A status write (offset 2) loads bits 5 and 6 from the data and leaves bit 0 unchanged. Writing 1 to bit 1 (error) or to bit 2 (interrupt) clears that bit. Status reads return the stored value ANDed with 0x67.
- R4: Offsets 4 to 7 hold the table pointer, least significant byte first, with bits 1:0 forced to zero. A read of offset 4 returns the last byte written there without the mask.
- R5: In a descriptor, word 0 gives the buffer address with bit 0 cleared. Word 1 bits 15:0 give the byte count with bit 0 cleared, and a count of 0 means 65536. Word 1 bit 31 marks the last entry. The next descriptor is read from the working pointer plus 8.
- R6: A request on a channel whose active bit is 0 completes with result 3. It makes no memory access and leaves the status unchanged.
- R7: A request that ends inside a buffer completes with result 0. It clears error, keeps active, and the next request continues at the following byte of that buffer.
- R8: A request that ends exactly at the end of a non-last buffer completes with result 0. It clears error, keeps active, and fetches the next descriptor.
- R9: A request that ends exactly at the end of the last buffer completes with result 1 and clears both active and error.
- R10: A request that still has bytes to move after the last buffer is used up completes with result 2. It sets error and leaves active at 1. A further request in that state also returns 2.
- R11: A rising `dev_irq[n]` sets status bit 2 of channel n, and a falling `dev_irq[n]` clears it. `irq[n]` equals status bit 2.
- R12: Each data byte is one memory access to the word-aligned address. A write carries the byte replicated on all lanes with `mem_be` = 1 << addr[1:0]. A read takes lane addr[1:0].
- R13: When a hardware event that sets status bit 1 or 2 lands in the same cycle as a software write-one-to-clear of that bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| io_base | input | 16 | I/O base; bits 3:0 ignored |
| io_en | input | 1 | I/O decode enable |
| io_addr | input | 16 | Register access address |
| io_wr | input | 1 | Register write strobe |
| io_wdata | input | 8 | Register write data |
| io_rdata | output | 8 | Register read data (combinational) |
| xfer_valid | input | 1 | Transfer request valid |
| xfer_ready | output | 1 | Engine can accept a request |
| xfer_ch | input | 1 | Channel of the request |
| xfer_to_dev | input | 1 | 1: memory to device, 0: device to memory |
| xfer_len | input | 17 | Request length in bytes |
| xfer_done | output | 1 | One-cycle completion pulse |
| xfer_res | output | 2 | 0 resumable, 1 table end, 2 overrun, 3 ignored |
| din_data | input | 8 | Byte from device |
| din_valid | input | 1 | Device byte valid |
| din_ready | output | 1 | Device byte taken |
| dout_data | output | 8 | Byte to device |
| dout_valid | output | 1 | Byte to device valid |
| dout_ready | input | 1 | Device takes byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |
| mem_ready | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| dev_irq | input | 2 | Device interrupt level per channel |
| irq | output | 2 | Interrupt output per channel |

## Verification
Status bit 2 can receive a rising device interrupt and a software write-one-to-clear in the same clock. Status bit 1 can likewise be set by the engine while software clears it. The bench provokes the interrupt case by raising `dev_irq[1]` on the same falling edge that presents a status write of 0x04 to channel 1. It then reads the status and `irq[1]` after the next edge, and both must show the bit set. The error bit is checked on its own: an overrun must set it, and a later write-one-to-clear must remove it while active stays set.

// File: rtl/sg_busmaster_dma.sv
module sg_busmaster_dma (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_base,
  input  logic        io_en,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic        xfer_valid,
  output logic        xfer_ready,
  input  logic        xfer_ch,
  input  logic        xfer_to_dev,
  input  logic [16:0] xfer_len,
  output logic        xfer_done,
  output logic [1:0]  xfer_res,
  input  logic [7:0]  din_data,
  input  logic        din_valid,
  output logic        din_ready,
  output logic [7:0]  dout_data,
  output logic        dout_valid,
  input  logic        dout_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata,
  input  logic [1:0]  dev_irq,
  output logic [1:0]  irq
);
  typedef enum logic [2:0] {E_IDLE, E_F0, E_F1, E_WR, E_RD, E_OUT, E_END} est_t;

  logic [7:0]  cmd [2];
  logic [7:0]  ptr0 [2];
  logic [31:0] ptr [2], cur [2], badr [2];
  logic [16:0] cnt [2];
  logic [1:0]  eot, act, err, ist, s5, s6, fpend, irq_q;
  est_t        st;
  logic        ech, xon, dir;
  logic [16:0] rem;
  logic [7:0]  obuf;
  logic [31:0] dw0;
  logic [1:0]  res;

  logic       hit, wr_hit, rch, step;
  logic [2:0] off;
  logic [1:0] start_w;

  assign hit    = io_en && (io_base[15:4] != 12'h0) && (io_addr[15:4] == io_base[15:4]);
  assign wr_hit = hit && io_wr;
  assign rch    = io_addr[3];
  assign off    = io_addr[2:0];
  assign start_w[0] = wr_hit && !rch && off == 3'd0 && io_wdata[0] && !cmd[0][0];
  assign start_w[1] = wr_hit &&  rch && off == 3'd0 && io_wdata[0] && !cmd[1][0];

  always_comb begin
    io_rdata = 8'hFF;
    if (hit)
      case (off)
        3'd0: io_rdata = cmd[rch];
        3'd2: io_rdata = {1'b0, s6[rch], s5[rch], 2'b00, ist[rch], err[rch], act[rch]} & 8'h67;
        3'd4: io_rdata = ptr0[rch];
        3'd5: io_rdata = ptr[rch][15:8];
        3'd6: io_rdata = ptr[rch][23:16];
        3'd7: io_rdata = ptr[rch][31:24];
        default: io_rdata = 8'hFF;
      endcase
  end

  assign xfer_ready = (st == E_IDLE) && (fpend == 2'b00);
  assign xfer_done  = (st == E_END);
  assign xfer_res   = res;
  assign mem_req    = (st == E_F0) || (st == E_F1) || (st == E_RD) || (st == E_WR && din_valid);
  assign mem_we     = (st == E_WR);
  assign mem_addr   = (st == E_F0) ? cur[ech] : (st == E_F1) ? cur[ech] + 32'd4
                                   : {badr[ech][31:2], 2'b00};
  assign mem_be     = (st == E_WR) ? (4'b0001 << badr[ech][1:0]) : 4'hF;
  assign mem_wdata  = {4{din_data}};
  assign din_ready  = (st == E_WR) && mem_ready;
  assign dout_valid = (st == E_OUT);
  assign dout_data  = obuf;
  assign irq        = ist;
  assign step       = (st == E_WR && din_valid && mem_ready) || (st == E_OUT && dout_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        cmd[c] <= '0; ptr0[c] <= '0; ptr[c] <= '0; cur[c] <= '0;
        badr[c] <= '0; cnt[c] <= '0;
      end
      eot <= '0; act <= '0; err <= '0; ist <= '0; s5 <= '0; s6 <= '0;
      fpend <= '0; irq_q <= '0;
      st <= E_IDLE; ech <= 1'b0; xon <= 1'b0; dir <= 1'b0;
      rem <= '0; obuf <= '0; dw0 <= '0; res <= '0;
    end else begin
      // software register writes
      if (wr_hit)
        case (off)
          3'd0: begin
            cmd[rch] <= io_wdata;
            if (io_wdata[0] && !cmd[rch][0]) begin
              act[rch] <= 1'b1; cur[rch] <= ptr[rch]; fpend[rch] <= 1'b1;
            end else if (!io_wdata[0] && cmd[rch][0]) act[rch] <= 1'b0;
          end
          3'd2: begin
            s5[rch] <= io_wdata[5]; s6[rch] <= io_wdata[6];
            if (io_wdata[1]) err[rch] <= 1'b0;
            if (io_wdata[2]) ist[rch] <= 1'b0;
          end
          3'd4: begin ptr[rch][7:0] <= {io_wdata[7:2], 2'b00}; ptr0[rch] <= io_wdata; end
          3'd5: ptr[rch][15:8]  <= io_wdata;
          3'd6: ptr[rch][23:16] <= io_wdata;
          3'd7: ptr[rch][31:24] <= io_wdata;
          default: ;
        endcase

      // engine
      case (st)
        E_IDLE:
          if (fpend != 2'b00) begin
            ech <= fpend[0] ? 1'b0 : 1'b1; xon <= 1'b0; st <= E_F0;
            if (fpend[0]) begin if (!start_w[0]) fpend[0] <= 1'b0; end
            else if (!start_w[1]) fpend[1] <= 1'b0;
          end else if (xfer_valid) begin
            ech <= xfer_ch; dir <= xfer_to_dev; rem <= xfer_len;
            if (!act[xfer_ch]) begin res <= 2'd3; st <= E_END; end
            else if (xfer_len == 17'd0) begin res <= 2'd0; st <= E_END; end
            else if (cnt[xfer_ch] == 17'd0) begin err[xfer_ch] <= 1'b1; res <= 2'd2; st <= E_END; end
            else begin xon <= 1'b1; st <= xfer_to_dev ? E_RD : E_WR; end
          end
        E_F0: if (mem_ready) begin dw0 <= mem_rdata; st <= E_F1; end
        E_F1: if (mem_ready) begin
          badr[ech] <= {dw0[31:1], 1'b0};
          cnt[ech]  <= (mem_rdata[15:1] == 15'd0) ? 17'h10000 : {1'b0, mem_rdata[15:1], 1'b0};
          eot[ech]  <= mem_rdata[31];
          if (!start_w[ech]) cur[ech] <= cur[ech] + 32'd8;
          st <= !xon ? E_IDLE : (rem == 17'd0) ? E_END : (dir ? E_RD : E_WR);
        end
        E_RD: if (mem_ready) begin obuf <= mem_rdata[8*badr[ech][1:0] +: 8]; st <= E_OUT; end
        E_END: begin st <= E_IDLE; xon <= 1'b0; end
        default: ;
      endcase

      if (step) begin
        badr[ech] <= badr[ech] + 32'd1;
        cnt[ech]  <= cnt[ech] - 17'd1;
        rem       <= rem - 17'd1;
        if (cnt[ech] == 17'd1) begin
          if (rem == 17'd1) begin
            err[ech] <= 1'b0;
            if (eot[ech]) begin
              if (!start_w[ech]) act[ech] <= 1'b0;
              res <= 2'd1; st <= E_END;
            end else begin res <= 2'd0; st <= E_F0; end
          end else if (eot[ech]) begin err[ech] <= 1'b1; res <= 2'd2; st <= E_END; end
          else st <= E_F0;
        end else if (rem == 17'd1) begin err[ech] <= 1'b0; res <= 2'd0; st <= E_END; end
        else st <= dir ? E_RD : E_WR;
      end

      // device interrupt levels
      for (int c = 0; c < 2; c++) begin
        if (dev_irq[c] && !irq_q[c]) ist[c] <= 1'b1;
        else if (!dev_irq[c] && irq_q[c]) ist[c] <= 1'b0;
      end
      irq_q <= dev_irq;
    end
  end

  // R2
  start_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_w[0] |=> act[0]);

  // R6
  inactive_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready && !act[xfer_ch]) |=> (xfer_done && xfer_res == 2'd3 && !mem_req));

  // R9
  table_end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && xfer_res == 2'd1) |-> (!act[ech] && !err[ech]));

  // R11
  irq_follows_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_irq[1]) |=> irq[1]);

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  // R3
  always_comb
    if (rst_n && hit && off == 3'd2)
      status_mask_chk: assert ((io_rdata & 8'h98) == 8'h00);
endmodule

// File: tb/sg_busmaster_dma_tb.sv
module sg_busmaster_dma_tb_top;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [15:0] io_base = 16'h1C05, io_addr = 0;
  logic io_en = 1, io_wr = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic xfer_valid = 0, xfer_ready, xfer_ch = 0, xfer_to_dev = 0, xfer_done;
  logic [16:0] xfer_len = 0;
  logic [1:0] xfer_res;
  logic [7:0] din_data = 8'h10, dout_data;
  logic din_valid = 1, din_ready, dout_valid, dout_ready = 1;
  logic mem_req, mem_we, mem_ready = 1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic [1:0] dev_irq = 0, irq;

  sg_busmaster_dma dut_i (.*);

  logic [31:0] bmem [256];
  int wcount = 0, ocnt = 0, checks = 0, errors = 0;
  logic [7:0] obytes [16];

  assign mem_rdata = bmem[mem_addr[9:2]];
  always @(posedge clk) begin
    if (mem_req && mem_we && mem_ready) begin
      for (int i = 0; i < 4; i++)
        if (mem_be[i]) bmem[mem_addr[9:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
      wcount = wcount + 1;
    end
    if (din_valid && din_ready) din_data <= din_data + 8'd1;
    if (dout_valid && dout_ready) begin obytes[ocnt % 16] = dout_data; ocnt = ocnt + 1; end
  end

  task automatic check(string tag, logic [31:0] act_v, logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic io_read(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; #1 d = io_rdata;
  endtask

  task automatic do_xfer(logic ch, logic to_dev, logic [16:0] len, output logic [1:0] r);
    @(negedge clk);
    while (!xfer_ready) @(negedge clk);
    xfer_valid = 1; xfer_ch = ch; xfer_to_dev = to_dev; xfer_len = len;
    @(negedge clk); xfer_valid = 0;
    while (!xfer_done) @(negedge clk);
    r = xfer_res;
  endtask

  task automatic set_ptr(logic [15:0] b, logic [31:0] p);
    io_write(b + 4, p[7:0]); io_write(b + 5, p[15:8]);
    io_write(b + 6, p[23:16]); io_write(b + 7, p[31:24]);
  endtask

  logic [7:0] rd;
  logic [1:0] r;

  task automatic t_reset;
    io_read(16'h1C02, rd); check("R3 reset status", rd, 8'h00);
    io_read(16'h1C00, rd); check("R2 reset command", rd, 8'h00);
    check("R11 reset irq", irq, 2'b00);
  endtask

  task automatic t_decode;
    io_en = 0; io_write(16'h1C05, 8'h55); io_read(16'h1C05, rd);
    check("R1 disabled read", rd, 8'hFF);
    io_en = 1; io_read(16'h1C05, rd); check("R1 disabled write ignored", rd, 8'h00);
    io_write(16'h1C0D, 8'hA4); io_read(16'h1C0D, rd); check("R1 channel 1 at base+8", rd, 8'hA4);
    io_read(16'h1C05, rd); check("R1 channel 0 untouched", rd, 8'h00);
    io_base = 16'h0003; io_read(16'h0005, rd); check("R1 zero base silent", rd, 8'hFF);
    io_base = 16'h1C05;
  endtask

  task automatic t_regs;
    io_write(16'h1C04, 8'h03); io_read(16'h1C04, rd); check("R4 offset4 unmasked", rd, 8'h03);
    io_write(16'h1C05, 8'h01); io_read(16'h1C05, rd); check("R4 offset5", rd, 8'h01);
    io_write(16'h1C02, 8'hFF); io_read(16'h1C02, rd); check("R3 status write FF", rd, 8'h60);
    io_write(16'h1C02, 8'h00); io_read(16'h1C02, rd); check("R3 status write 00", rd, 8'h00);
    io_write(16'h1C00, 8'h80); io_read(16'h1C00, rd); check("R2 command readback", rd, 8'h80);
  endtask

  task automatic t_inactive;
    int w0;
    w0 = wcount; do_xfer(0, 0, 17'd4, r);
    check("R6 inactive result", r, 2'd3);
    check("R6 no memory write", wcount, w0);
    io_read(16'h1C02, rd); check("R6 status unchanged", rd, 8'h00);
  endtask

  task automatic t_table;
    // table at 0x100 (pointer written as 0x103 above)
    bmem[64] = 32'h0000_0201; bmem[65] = 32'h0000_0005;
    bmem[66] = 32'h0000_0240; bmem[67] = 32'h8000_0006;
    io_write(16'h1C00, 8'h01); io_read(16'h1C02, rd); check("R2 start sets active", rd, 8'h01);
    do_xfer(0, 0, 17'd3, r); check("R7 partial result", r, 2'd0);
    check("R12 byte lanes partial", bmem[128], 32'hEE12_1110);
    io_read(16'h1C02, rd); check("R7 still active", rd, 8'h01);
    do_xfer(0, 0, 17'd1, r); check("R8 boundary result", r, 2'd0);
    check("R7 resumed byte", bmem[128], 32'h1312_1110);
    check("R5 count bit0 cleared", bmem[129], 32'hEEEE_EEEE);
    io_read(16'h1C02, rd); check("R8 active after boundary", rd, 8'h01);
    do_xfer(0, 0, 17'd6, r); check("R9 table end result", r, 2'd1);
    check("R5 second descriptor lo", bmem[144], 32'h1716_1514);
    check("R12 second descriptor hi", bmem[145], 32'hEEEE_1918);
    io_read(16'h1C02, rd); check("R9 active and error cleared", rd, 8'h00);
  endtask

  task automatic t_overrun;
    bmem[96] = 32'h0000_0280; bmem[97] = 32'h8000_0004; bmem[160] = 32'h4433_2211;
    io_write(16'h1C00, 8'h00); set_ptr(16'h1C00, 32'h0000_0180);
    io_write(16'h1C00, 8'h01);
    ocnt = 0; do_xfer(0, 1, 17'd6, r);
    check("R10 overrun result", r, 2'd2);
    check("R12 read lanes", {obytes[3], obytes[2], obytes[1], obytes[0]}, 32'h4433_2211);
    check("R10 bytes moved", ocnt, 4);
    io_read(16'h1C02, rd); check("R10 error set active kept", rd, 8'h03);
    do_xfer(0, 1, 17'd2, r); check("R10 repeat overrun", r, 2'd2);
    io_write(16'h1C02, 8'h02); io_read(16'h1C02, rd); check("R3 W1C error", rd, 8'h01);
  endtask

  task automatic t_zero_count;
    bmem[112] = 32'h0000_0300; bmem[113] = 32'h8000_0000;
    io_write(16'h1C00, 8'h00); io_read(16'h1C02, rd); check("R2 stop clears active", rd, 8'h00);
    set_ptr(16'h1C00, 32'h0000_01C0); io_write(16'h1C00, 8'h01);
    do_xfer(0, 0, 17'd4, r); check("R5 zero count is 64K", r, 2'd0);
    io_read(16'h1C02, rd); check("R5 still active", rd, 8'h01);
  endtask

  task automatic t_irq;
    @(negedge clk); dev_irq[1] = 1;
    @(negedge clk); check("R11 irq raised", irq, 2'b10);
    io_read(16'h1C0A, rd); check("R11 status bit2", rd, 8'h04);
    io_write(16'h1C0A, 8'h04); io_read(16'h1C0A, rd); check("R3 W1C interrupt", rd, 8'h00);
    check("R11 irq follows status", irq, 2'b00);
    @(negedge clk); dev_irq[1] = 0;
    @(negedge clk);
    io_addr = 16'h1C0A; io_wdata = 8'h04; io_wr = 1; dev_irq[1] = 1;
    @(negedge clk); io_wr = 0;
    io_read(16'h1C0A, rd); check("R13 set beats clear", rd, 8'h04);
    check("R13 irq set", irq, 2'b10);
    @(negedge clk); dev_irq[1] = 0;
    @(negedge clk); check("R11 irq falls", irq, 2'b00);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 32'hEEEE_EEEE;
    repeat (3) @(negedge clk); rst_n = 1;
    t_reset; t_decode; t_regs; t_inactive; t_table; t_overrun; t_zero_count; t_irq;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule